// File: doc/BRIEF.md
# Line Voltage Sag and Fault Warning Monitor

This block watches a stream of signed line-voltage samples and decides, one line period at a time, whether the supply has sagged. A period starts at a rising zero crossing, where the sign goes from negative to non-negative between two consecutive valid samples. The period ends at the next rising crossing. If every sample magnitude in that period lies below a programmable threshold, a sag event is raised as the period closes.

The block also takes a checksum-error flag from a parameter diagnosis engine. Both the sag event and the checksum error set sticky status bits. Software clears these bits by pulsing a write-one-to-clear input.

From that status the block drives three outputs:
- a warning pin, which carries the checksum fault and, when enabled, the sag;
- an interrupt pin, which carries the checksum fault;
- a metering-enable output, which stops energy pulse generation while a checksum fault is recorded.

Top module: `sag_warn_monitor`

## Requirements
- R1: After a synchronous reset, the sag status is 0, the checksum status is 2'b00, `warn_out` and `irq_out` are 0, and `meter_en` is 1.
- R2: A valid sample that forms a rising crossing closes the current period. If every valid sample of that period was below `sag_thresh`, `sag_status` reads 1 one clock after that sample. The period includes the crossing sample that opened it and excludes the one that closes it.
- R3: A single sample in the period with magnitude greater than or equal to `sag_thresh` prevents the sag for that period. The comparison is strict: a magnitude of threshold-1 still counts as below.
- R4: No sag is declared at the first rising crossing after reset. That crossing only opens the first complete period. The first valid sample after reset only records its sign.
- R5: Negative samples are compared by their absolute value. The most negative code 16'sh8000 has a magnitude of 32768.
- R6: Samples presented while `smp_vld` is 0 have no effect on crossing detection or on the below-threshold tracking.
- R7: `sag_status` is set regardless of `sag_warn_en`. `warn_out` reflects the sag status only while `sag_warn_en` is 1, and it follows a change of `sag_warn_en` without delay.
- R8: When `cksum_err` is 1 at a clock edge, after that edge `cal_status` reads 2'b11, `warn_out` and `irq_out` are 1, and `meter_en` is 0. `cal_status` takes only the values 2'b00 and 2'b11.
- R9: Bit 0 of `clr_w1c` clears the sag status and bit 1 clears the checksum status, effective one clock later. A set condition in the same cycle wins over the clear. Once all enabled sources are cleared, `warn_out` returns to 0.
- R10: Both status fields are sticky. The checksum status and the blocked `meter_en` persist after `cksum_err` drops, until they are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed two's-complement voltage sample |
| sag_thresh | input | 16 | Unsigned magnitude threshold |
| sag_warn_en | input | 1 | Routes sag status to the warning pin |
| cksum_err | input | 1 | Checksum error from the diagnosis engine |
| clr_w1c | input | 2 | Write-one-to-clear pulses: bit 0 sag, bit 1 checksum |
| sag_status | output | 1 | Sticky sag flag |
| cal_status | output | 2 | Sticky checksum fault field |
| warn_out | output | 1 | Fatal warning pin |
| irq_out | output | 1 | Interrupt pin |
| meter_en | output | 1 | Metering enable, low on checksum fault |

## Verification
The assertions assume that `cksum_err`, `clr_w1c` and the sample strobe are synchronous to `clk`. They also assume that `clr_w1c` is a one-cycle pulse whose effect is judged at the following edge. The stimulus changes every input only at the falling clock edge, including threshold and enable updates. It presents samples as square half-waves, so every rising crossing is a single known sample. Invalid samples carry extreme values of both signs, so any leak through the strobe would create a false crossing or spoil the period.

// File: rtl/sagmon_pkg.sv
package sagmon_pkg;

    typedef enum logic [1:0] {
        PH_EMPTY = 2'd0,
        PH_SEEK  = 2'd1,
        PH_TRACK = 2'd2
    } det_phase_e;

    localparam logic [1:0] CAL_FAULT = 2'b11;
    localparam logic [1:0] CAL_OK    = 2'b00;

    localparam int CLR_SAG_BIT = 0;
    localparam int CLR_CAL_BIT = 1;
    localparam int CLR_W       = 2;

    typedef struct packed {
        logic       sag;
        logic [1:0] cal;
    } fault_stat_t;

    function automatic logic rising_edge_of(input logic prev_neg, input logic cur_neg);
        return prev_neg & ~cur_neg;
    endfunction

endpackage

// File: rtl/sag_mag_cmp.sv
module sag_mag_cmp #(
    parameter int SMP_W = 16
) (
    input  logic signed [SMP_W-1:0] smp,
    input  logic        [SMP_W-1:0] thresh,
    output logic                    is_neg,
    output logic                    below
);
    logic [SMP_W-1:0] mag;

    always_comb begin
        is_neg = smp[SMP_W-1];
        mag    = is_neg ? (~smp + 1'b1) : smp;
        below  = mag < thresh;
    end
endmodule

// File: rtl/sag_cycle_detect.sv
module sag_cycle_detect
    import sagmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic cur_neg,
    input  logic cur_below,
    output logic sag_evt
);
    det_phase_e phase;
    logic       prev_neg;
    logic       low_ok;
    logic       rise;

    always_comb begin
        rise    = rising_edge_of(prev_neg, cur_neg);
        sag_evt = vld && (phase == PH_TRACK) && rise && low_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_EMPTY;
            prev_neg <= 1'b0;
            low_ok   <= 1'b0;
        end else if (vld) begin
            prev_neg <= cur_neg;
            case (phase)
                PH_EMPTY: phase <= PH_SEEK;
                PH_SEEK: begin
                    if (rise) begin
                        phase  <= PH_TRACK;
                        low_ok <= cur_below;
                    end
                end
                PH_TRACK: low_ok <= rise ? cur_below : (low_ok & cur_below);
                default:  phase <= PH_EMPTY;
            endcase
        end
    end

    // R6
    invalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld |=> ($stable(prev_neg) && $stable(low_ok) && $stable(phase)));

    // R4
    no_early_sag_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EMPTY) |=> !sag_evt);
endmodule

// File: rtl/fault_status.sv
module fault_status
    import sagmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sag_evt,
    input  logic              cksum_err,
    input  logic [CLR_W-1:0]  clr_w1c,
    input  logic              sag_warn_en,
    output fault_stat_t       stat,
    output logic              warn,
    output logic              irq,
    output logic              meter_en
);
    logic cal_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat.sag <= 1'b0;
            stat.cal <= CAL_OK;
        end else begin
            if (sag_evt)
                stat.sag <= 1'b1;
            else if (clr_w1c[CLR_SAG_BIT])
                stat.sag <= 1'b0;

            if (cksum_err)
                stat.cal <= CAL_FAULT;
            else if (clr_w1c[CLR_CAL_BIT])
                stat.cal <= CAL_OK;
        end
    end

    always_comb begin
        cal_any  = |stat.cal;
        irq      = cal_any;
        meter_en = ~cal_any;
        warn     = cal_any | (stat.sag & sag_warn_en);
    end

    // R8
    cal_encoding_chk: assert property (@(posedge clk) disable iff (rst)
        (stat.cal == CAL_OK) || (stat.cal == CAL_FAULT));

    // R9
    sag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_w1c[CLR_SAG_BIT] && !sag_evt) |=> !stat.sag);

    // R10
    sag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (stat.sag && !clr_w1c[CLR_SAG_BIT]) |=> stat.sag);

    // R10
    cal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_any && !clr_w1c[CLR_CAL_BIT]) |=> (stat.cal == CAL_FAULT));
endmodule

// File: rtl/sag_warn_monitor.sv
module sag_warn_monitor
    import sagmon_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_data,
    input  logic        [SMP_W-1:0] sag_thresh,
    input  logic                    sag_warn_en,
    input  logic                    cksum_err,
    input  logic [1:0]              clr_w1c,
    output logic                    sag_status,
    output logic [1:0]              cal_status,
    output logic                    warn_out,
    output logic                    irq_out,
    output logic                    meter_en
);
    logic        s_neg;
    logic        s_below;
    logic        sag_evt;
    fault_stat_t stat;

    sag_mag_cmp #(.SMP_W(SMP_W)) u_cmp (
        .smp    (smp_data),
        .thresh (sag_thresh),
        .is_neg (s_neg),
        .below  (s_below)
    );

    sag_cycle_detect u_det (
        .clk       (clk),
        .rst       (rst),
        .vld       (smp_vld),
        .cur_neg   (s_neg),
        .cur_below (s_below),
        .sag_evt   (sag_evt)
    );

    fault_status u_stat (
        .clk         (clk),
        .rst         (rst),
        .sag_evt     (sag_evt),
        .cksum_err   (cksum_err),
        .clr_w1c     (clr_w1c),
        .sag_warn_en (sag_warn_en),
        .stat        (stat),
        .warn        (warn_out),
        .irq         (irq_out),
        .meter_en    (meter_en)
    );

    assign sag_status = stat.sag;
    assign cal_status = stat.cal;

    // R2
    sag_latch_chk: assert property (@(posedge clk) disable iff (rst)
        sag_evt |=> sag_status);

    // R8
    cksum_block_chk: assert property (@(posedge clk) disable iff (rst)
        cksum_err |=> (!meter_en && irq_out && warn_out && cal_status == 2'b11));
endmodule

// File: tb/sim_sag_warn_monitor.sv
`timescale 1ns/1ps
module sim_sag_warn_monitor;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_vld = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic        [15:0] sag_thresh = 16'd100;
    logic               sag_warn_en = 1'b1;
    logic               cksum_err = 1'b0;
    logic [1:0]         clr_w1c = 2'b00;
    logic               sag_status;
    logic [1:0]         cal_status;
    logic               warn_out, irq_out, meter_en;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [15:0] st_thresh = 16'd100;
    logic        st_wen    = 1'b1;
    logic        st_ck     = 1'b0;
    logic        exp_sag   = 1'b0;
    logic [1:0]  exp_cal   = 2'b00;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    sag_warn_monitor u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .sag_thresh(sag_thresh), .sag_warn_en(sag_warn_en), .cksum_err(cksum_err),
        .clr_w1c(clr_w1c), .sag_status(sag_status), .cal_status(cal_status),
        .warn_out(warn_out), .irq_out(irq_out), .meter_en(meter_en)
    );

    function automatic logic [5:0] expect_word(logic s, logic [1:0] c, logic wen);
        return {s, c, (s & wen) | (c != 2'b00), c != 2'b00, c == 2'b00};
    endfunction

    function automatic void compare(logic [5:0] exp_w, string tag);
        logic [5:0] act;
        act = {sag_status, cal_status, warn_out, irq_out, meter_en};
        checks++;
        if (act !== exp_w) begin
            errors++;
            $display("FAIL %s: actual {sag,cal,warn,irq,meter}=%b expected %b", tag, act, exp_w);
        end
    endfunction

    task automatic drive(input logic vld, input logic signed [15:0] s,
                         input logic [1:0] clr, input string tag);
        @(negedge clk);
        smp_vld     = vld;
        smp_data    = s;
        clr_w1c     = clr;
        sag_thresh  = st_thresh;
        sag_warn_en = st_wen;
        cksum_err   = st_ck;
        exp_q.push_back(expect_word(exp_sag, exp_cal, st_wen));
        tag_q.push_back(tag);
    endtask

    task automatic half(input logic signed [15:0] v, input int len,
                        input bit sag_first, input string tag);
        for (int i = 0; i < len; i++) begin
            if (i == 0 && sag_first) exp_sag = 1'b1;
            drive(1'b1, v, 2'b00, tag);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end

    initial begin
        wait (cyc >= 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycles=%0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(expect_word(1'b0, 2'b00, 1'b1), "R1 reset state");
        rst = 1'b0;

        // R4: first period only opens, no sag at first rising crossing
        half(16'sd50, 4, 0, "R4 first sample");
        half(-16'sd50, 4, 0, "R4");
        half(16'sd50, 4, 0, "R4 first crossing");
        half(-16'sd50, 4, 0, "R2 low period");
        // R2 / R7: full low period closes, sag set and warned
        half(16'sd50, 2, 1, "R2 sag at crossing");

        // R9: clear sag, warning drops
        exp_sag = 1'b0;
        drive(1'b0, 16'sd0, 2'b01, "R9 clear sag");
        // R3 / R5: negative magnitude equal to threshold spoils the period
        half(-16'sd100, 3, 0, "R5 neg equal");
        half(16'sd50, 2, 0, "R3 equal blocks sag");
        // R3: threshold-1 still below
        half(-16'sd99, 3, 0, "R3 just below");
        half(16'sd50, 2, 1, "R3 sag below");

        // R7 / R6: warning masked, invalid samples ignored
        exp_sag = 1'b0;
        st_wen  = 1'b0;
        drive(1'b0, 16'sd0, 2'b01, "R9 clear sag again");
        half(-16'sd50, 2, 0, "R6");
        drive(1'b0, -16'sd30000, 2'b00, "R6 invalid neg");
        drive(1'b0, 16'sd30000, 2'b00, "R6 invalid pos");
        drive(1'b0, -16'sd30000, 2'b00, "R6 invalid neg");
        half(-16'sd50, 1, 0, "R6");
        half(16'sd50, 2, 1, "R7 sag with warn masked");
        st_wen = 1'b1;
        drive(1'b0, 16'sd0, 2'b00, "R7 warn follows enable");

        // R5: most negative code
        exp_sag = 1'b0;
        drive(1'b0, 16'sd0, 2'b01, "R9 clear");
        half(16'sh8000, 1, 0, "R5 min code");
        half(16'sd50, 1, 0, "R5 min code blocks sag");
        st_thresh = 16'd40000;
        half(16'sh8000, 2, 0, "R5 min below 40000");
        half(16'sd50, 1, 1, "R5 sag with min code");

        // R8 / R9 / R10: checksum fault path
        exp_sag = 1'b0;
        drive(1'b0, 16'sd0, 2'b01, "R9 clear");
        st_ck   = 1'b1;
        exp_cal = 2'b11;
        drive(1'b0, 16'sd0, 2'b00, "R8 fault raises");
        drive(1'b0, 16'sd0, 2'b10, "R9 set wins over clear");
        st_ck = 1'b0;
        drive(1'b0, 16'sd0, 2'b00, "R10 fault sticky");
        drive(1'b0, 16'sd0, 2'b00, "R10 meter still blocked");
        exp_cal = 2'b00;
        drive(1'b0, 16'sd0, 2'b10, "R9 clear fault");

        // R9: sag event and sag clear in the same cycle
        half(-16'sd50, 1, 0, "R9");
        exp_sag = 1'b1;
        drive(1'b1, 16'sd50, 2'b01, "R9 sag wins over clear");
        drive(1'b0, 16'sd0, 2'b00, "R10 sag sticky");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule